// File: doc/BRIEF.md
# Dimension-Order Mesh Route Selector

This block is the route-compute stage that runs once per hop in a router for a two-dimensional mesh. The switch supplies its own coordinates, and the packet header supplies the target coordinates. When the header strobe is high, the block subtracts the two pairs to get a signed offset in each axis. It then names exactly one of five output ports: the two x-direction neighbours, the two y-direction neighbours, or the attached processor.

Horizontal movement always comes first. While the x offset is non-zero, only a west or east port can be chosen. Vertical ports become possible only once the column already matches. Every route therefore has the shape "x moves, at most one turn, y moves" and never turns from y back to x. This keeps channel use monotonic on a bidirectional mesh, so no deadlock cycle can form. The decision is held in a register, so the selected port is valid one clock after the header.

Top module: `dor_route_sel`

## Requirements
- R1: When the destination column is below the current column (x offset negative), port_sel is 5'b00001 (bit 0, west).
- R2: When the destination column is above the current column (x offset positive), port_sel is 5'b00010 (bit 1, east), whatever the y offset is.
- R3: When the x offset is zero and the destination row is below the current row, port_sel is 5'b00100 (bit 2, south).
- R4: When the x offset is zero and the destination row is above the current row, port_sel is 5'b01000 (bit 3, north).
- R5: When both offsets are zero, port_sel is 5'b10000 (bit 4, local processor).
- R6: Whenever port_valid is high, exactly one bit of port_sel is set.
- R7: port_valid rises on the first rising clock edge after hdr_valid is sampled high, which is a latency of one cycle. A one-cycle strobe gives a one-cycle port_valid pulse.
- R8: A cycle with hdr_valid low produces port_valid low and port_sel all zero on the next edge, whatever values the coordinate inputs hold.
- R9: While rst_n is low, port_valid is low and port_sel is zero.
- R10: Offsets are correct over the whole unsigned coordinate range, including the extreme pairs 0 versus 2^COORD_W-1 in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header coordinates are present this cycle |
| cur_x | input | COORD_W | Column of this switch |
| cur_y | input | COORD_W | Row of this switch |
| dst_x | input | COORD_W | Destination column from the header |
| dst_y | input | COORD_W | Destination row from the header |
| port_valid | output | 1 | port_sel holds a decision |
| port_sel | output | 5 | One-hot port: bit 4 local, 3 north, 2 south, 1 east, 0 west |

## Verification
The bench builds the block with COORD_W = 3. This shrinks the input space to 4096 coordinate combinations, so the sweep covers every current and destination pair. Every sign combination of the two offsets is reached, including the largest positive and negative differences, where a subtraction with no extra bit would wrap. Short strobes with gaps and idle cycles carrying garbage coordinates exercise the latency and the idle behaviour.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int NUM_DIMS  = 2;
    localparam int NUM_PORTS = 5;

    localparam int DIM_X = 0;
    localparam int DIM_Y = 1;

    // bit positions of the one-hot port vector
    localparam int PORT_WEST  = 0;
    localparam int PORT_EAST  = 1;
    localparam int PORT_SOUTH = 2;
    localparam int PORT_NORTH = 3;
    localparam int PORT_LOCAL = 4;

    typedef struct packed {
        logic                 vld;
        logic [NUM_PORTS-1:0] sel;
    } route_state_t;

endpackage

// File: rtl/axis_offset.sv
module axis_offset #(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] here,
    input  logic [COORD_W-1:0] there,
    output logic               go_neg,
    output logic               go_pos
);
    localparam int DELTA_W = COORD_W + 1;

    logic signed [DELTA_W-1:0] delta;

    always_comb begin
        delta  = $signed({1'b0, there}) - $signed({1'b0, here});
        go_neg = delta[DELTA_W-1];
        go_pos = !delta[DELTA_W-1] && (delta != '0);
    end

    // the two directions of one axis never both apply
    always_comb begin
        a_r10_axis_exclusive: assert (!(go_neg && go_pos));
    end

endmodule

// File: rtl/port_decode.sv
module port_decode
    import mesh_route_pkg::*;
(
    input  logic [NUM_DIMS-1:0]  dim_neg,
    input  logic [NUM_DIMS-1:0]  dim_pos,
    output logic [NUM_PORTS-1:0] sel
);
    always_comb begin
        sel = '0;
        if (dim_neg[DIM_X])      sel[PORT_WEST]  = 1'b1;
        else if (dim_pos[DIM_X]) sel[PORT_EAST]  = 1'b1;
        else if (dim_neg[DIM_Y]) sel[PORT_SOUTH] = 1'b1;
        else if (dim_pos[DIM_Y]) sel[PORT_NORTH] = 1'b1;
        else                     sel[PORT_LOCAL] = 1'b1;
    end

    // while x is unresolved, no y port or local port may be chosen
    always_comb begin
        a_r2_x_before_y: assert (!(|(dim_neg[DIM_X] | dim_pos[DIM_X]))
                                 || (sel[PORT_SOUTH] == 1'b0 && sel[PORT_NORTH] == 1'b0
                                     && sel[PORT_LOCAL] == 1'b0));
    end

endmodule

// File: rtl/dor_route_sel.sv
module dor_route_sel
    import mesh_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_valid,
    input  logic [COORD_W-1:0]   cur_x,
    input  logic [COORD_W-1:0]   cur_y,
    input  logic [COORD_W-1:0]   dst_x,
    input  logic [COORD_W-1:0]   dst_y,
    output logic                 port_valid,
    output logic [NUM_PORTS-1:0] port_sel
);
    logic [NUM_DIMS-1:0][COORD_W-1:0] here_c;
    logic [NUM_DIMS-1:0][COORD_W-1:0] there_c;
    logic [NUM_DIMS-1:0]              dim_neg;
    logic [NUM_DIMS-1:0]              dim_pos;
    logic [NUM_PORTS-1:0]             dec_sel;

    route_state_t route_d, route_q;

    always_comb begin
        here_c[DIM_X]  = cur_x;
        here_c[DIM_Y]  = cur_y;
        there_c[DIM_X] = dst_x;
        there_c[DIM_Y] = dst_y;
    end

    for (genvar g = 0; g < NUM_DIMS; g++) begin : g_axis
        axis_offset #(.COORD_W(COORD_W)) axis_i (
            .here   (here_c[g]),
            .there  (there_c[g]),
            .go_neg (dim_neg[g]),
            .go_pos (dim_pos[g])
        );
    end

    port_decode decode_i (
        .dim_neg (dim_neg),
        .dim_pos (dim_pos),
        .sel     (dec_sel)
    );

    always_comb begin
        route_d.vld = hdr_valid;
        route_d.sel = hdr_valid ? dec_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) route_q <= '0;
        else        route_q <= route_d;
    end

    assign port_valid = route_q.vld;
    assign port_sel   = route_q.sel;

    a_r6_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid |-> $countones(port_sel) == 1);

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> port_valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (!port_valid && port_sel == '0));

    a_r5_local: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cur_x == dst_x && cur_y == dst_y) |=> port_sel[PORT_LOCAL]);

    a_r1_west: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && dst_x < cur_x) |=> port_sel[PORT_WEST]);

    a_r2_east: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && dst_x > cur_x) |=> port_sel[PORT_EAST]);

    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!port_valid && port_sel == '0));

endmodule

// File: tb/dor_route_sel_tb_top.sv
module dor_route_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 3;
    localparam int CMAX       = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_valid = 1'b0;
    logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic          port_valid;
    logic [4:0]    port_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dor_route_sel #(.COORD_W(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_valid  (hdr_valid),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .dst_x      (dst_x),
        .dst_y      (dst_y),
        .port_valid (port_valid),
        .port_sel   (port_sel)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got valid/sel=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] expect_sel(input int cx, input int cy, input int dx, input int dy);
        int ox = dx - cx;
        int oy = dy - cy;
        if (ox < 0)      return 5'b00001;
        else if (ox > 0) return 5'b00010;
        else if (oy < 0) return 5'b00100;
        else if (oy > 0) return 5'b01000;
        else             return 5'b10000;
    endfunction

    function automatic string tag_for(input int cx, input int cy, input int dx, input int dy);
        int ox = dx - cx;
        int oy = dy - cy;
        if (ox == CMAX || ox == -CMAX || (ox == 0 && (oy == CMAX || oy == -CMAX)))
            return "R10 extreme offset";
        if (ox < 0)      return "R1 west";
        if (ox > 0)      return "R2 east";
        if (oy < 0)      return "R3 south";
        if (oy > 0)      return "R4 north";
        return "R5 local";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: quiet during reset, even with a strobe present
        hdr_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset", {port_valid, port_sel}, 6'b0);
        hdr_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", {port_valid, port_sel}, 6'b0);

        // exhaustive sweep, one header per cycle, held strobe
        for (int cx = 0; cx <= CMAX; cx++)
            for (int cy = 0; cy <= CMAX; cy++)
                for (int dx = 0; dx <= CMAX; dx++)
                    for (int dy = 0; dy <= CMAX; dy++) begin
                        cur_x = CW'(cx); cur_y = CW'(cy);
                        dst_x = CW'(dx); dst_y = CW'(dy);
                        hdr_valid = 1'b1;
                        @(negedge clk);
                        check(tag_for(cx, cy, dx, dy), {port_valid, port_sel},
                              {1'b1, expect_sel(cx, cy, dx, dy)});
                        // R6: single bit
                        checks++;
                        if ($countones(port_sel) != 1) begin
                            errors++;
                            $display("FAIL R6 one-hot: got %b expected one bit set", port_sel);
                        end
                    end

        // R8: idle cycles with varying coordinates stay quiet
        for (int k = 0; k < 8; k++) begin
            hdr_valid = 1'b0;
            cur_x = CW'(k); dst_x = CW'(CMAX - k); cur_y = CW'(k + 3); dst_y = CW'(k * 5);
            @(negedge clk);
            check("R8 idle", {port_valid, port_sel}, 6'b0);
        end

        // R7: isolated one-cycle strobes give one-cycle results
        for (int k = 0; k < 4; k++) begin
            cur_x = 3'd2; cur_y = 3'd2;
            dst_x = (k == 0) ? 3'd1 : 3'd2;
            dst_y = (k == 1) ? 3'd5 : ((k == 2) ? 3'd0 : 3'd2);
            hdr_valid = 1'b1;
            @(negedge clk);
            check("R7 pulse result", {port_valid, port_sel},
                  {1'b1, expect_sel(2, 2, int'(dst_x), int'(dst_y))});
            hdr_valid = 1'b0;
            @(negedge clk);
            check("R7 pulse ends", {port_valid, port_sel}, 6'b0);
        end

        // R9: reset in the middle of traffic
        hdr_valid = 1'b1; cur_x = 3'd0; dst_x = 3'd7;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 mid-run reset", {port_valid, port_sel}, 6'b0);
        @(negedge clk);
        rst_n = 1'b1;
        hdr_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule